// File: doc/BRIEF.md
# Grouped Bit-Count Class Selector

This block sits after the last layer of a hardware logic-gate classifier. It takes one wide vector of output bits and divides it into equal, contiguous slices, one slice per class. A class's score is the number of ones in its slice. The block returns the index of the class with the highest score, together with all the scores.

The scores are built serially. Every class has its own counter, and each cycle that counter adds one bit to its running binary value through a one-bit incrementer rather than a wide adder tree. All class counters advance together, one bit position per cycle. After the last position, a single cycle selects the winner. No offset or scaling is applied to the scores, because a common offset cannot move the winner.

Both sides of the block are valid/ready streams. A vector is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so it stays low during counting and while a result waits to be taken. A result is presented with `out_valid` and held, unchanged, until `out_ready` takes it. The cycle after that handshake, the block is idle again.

Top module: `vote_group_classifier`

## Requirements
- R1: Class i is scored from input bits `in_bits[i*GROUP_BITS +: GROUP_BITS]`. Class 0 uses the least significant slice.
- R2: The score of class i is the count of ones in its slice. It appears as an unsigned value at `out_scores[i*SW +: SW]`, where SW = $clog2(GROUP_BITS+1).
- R3: `out_class` is the index of a class whose score is not lower than any other class's score.
- R4: When several classes share the top score, `out_class` is the lowest of their indices.
- R5: `out_valid` rises exactly GROUP_BITS+1 clock cycles after the rising edge that accepts a vector.
- R6: `in_ready` is low from acceptance until the result is taken. `in_valid` and `in_bits` driven during that time are not accepted and have no effect on the result in progress.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_class` and `out_scores` hold their values. On the edge where `out_valid` and `out_ready` are both high, the result is consumed: `out_valid` falls and `in_ready` rises.
- R8: After reset, `out_valid` is 0, `in_ready` is 1 and every score reads 0.
- R9: Every accepted vector starts from zeroed counters, so its scores do not depend on any earlier vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is offered |
| in_ready | output | 1 | Block can accept a vector (idle) |
| in_bits | input | NUM_CLASSES*GROUP_BITS | Output bits of the last logic layer |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | $clog2(NUM_CLASSES) | Index of the winning class |
| out_scores | output | NUM_CLASSES*$clog2(GROUP_BITS+1) | Per-class bit counts, class 0 lowest |

## Verification
Two situations are hard to reach from random vectors. The first is a tie at the top score, since random slices rarely share the maximum. The second is a different vector offered while an earlier one is still being counted. Directed vectors cover the tie: an all-ones input, and slices filled to equal counts at chosen indices. To cover the second, the stimulus keeps `in_valid` high with the inverted vector throughout counting, then holds `out_ready` low for several cycles. This shows that neither the offered data nor the stall changes the result.

// File: rtl/vgc_pkg.sv
package vgc_pkg;

  typedef enum logic [1:0] {
    VGC_IDLE  = 2'd0,
    VGC_COUNT = 2'd1,
    VGC_PICK  = 2'd2,
    VGC_HOLD  = 2'd3
  } vgc_state_e;

  function automatic int score_width(input int group_bits);
    return $clog2(group_bits + 1);
  endfunction

  function automatic int index_width(input int classes);
    return (classes < 2) ? 1 : $clog2(classes);
  endfunction

endpackage

// File: rtl/vgc_shift_feed.sv
// Holds the accepted vector and moves it toward bit 0 one place per cycle.
// Tap i always shows the next unvisited bit of slice i.
module vgc_shift_feed #(
  parameter int NUM_CLASSES = 10,
  parameter int GROUP_BITS  = 100
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic                              shift,
  input  logic [NUM_CLASSES*GROUP_BITS-1:0] load_bits,
  output logic [NUM_CLASSES-1:0]            taps
);
  localparam int TOTAL = NUM_CLASSES * GROUP_BITS;

  logic [TOTAL-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (load) begin
      vec_q <= load_bits;
    end else if (shift) begin
      vec_q <= {1'b0, vec_q[TOTAL-1:1]};
    end
  end

  // Bits from the slice above spill into position i*G - 1 and above,
  // which the tap never reads before the slice is fully visited.
  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_tap
    assign taps[i] = vec_q[i*GROUP_BITS];
  end

endmodule

// File: rtl/vgc_bit_counter.sv
// Running count that grows by one input bit per step, through a ripple
// chain of half adders (no wide adder).
module vgc_bit_counter #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             bit_in,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;

  assign carry[0] = bit_in;
  for (genvar j = 0; j < WIDTH; j++) begin : g_ha
    assign sum[j]     = count[j] ^ carry[j];
    assign carry[j+1] = count[j] & carry[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (step) begin
      count <= sum;
    end
  end

endmodule

// File: rtl/vgc_max_pick.sv
// Linear scan for the largest score. A strict compare keeps the earliest
// index on ties.
module vgc_max_pick #(
  parameter int NUM_CLASSES = 10,
  parameter int SW          = 7,
  parameter int IW          = 4
) (
  input  logic [NUM_CLASSES*SW-1:0] scores,
  output logic [IW-1:0]             win_idx
);
  logic [SW-1:0] best;

  always_comb begin
    best    = scores[SW-1:0];
    win_idx = '0;
    for (int i = 1; i < NUM_CLASSES; i++) begin
      if (scores[i*SW +: SW] > best) begin
        best    = scores[i*SW +: SW];
        win_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/vote_group_classifier.sv
module vote_group_classifier
  import vgc_pkg::*;
#(
  parameter int NUM_CLASSES = 10,
  parameter int GROUP_BITS  = 100
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                in_valid,
  output logic                                                in_ready,
  input  logic [NUM_CLASSES*GROUP_BITS-1:0]                   in_bits,
  output logic                                                out_valid,
  input  logic                                                out_ready,
  output logic [index_width(NUM_CLASSES)-1:0]                 out_class,
  output logic [NUM_CLASSES*score_width(GROUP_BITS)-1:0]      out_scores
);
  localparam int SW  = score_width(GROUP_BITS);
  localparam int IW  = index_width(NUM_CLASSES);
  localparam int PW  = $clog2(GROUP_BITS + 1);
  localparam logic [PW-1:0] LAST_POS = PW'(GROUP_BITS - 1);

  vgc_state_e state_q;
  logic [PW-1:0] pos_q;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] class_q;
  logic [NUM_CLASSES-1:0] taps;
  logic accept, counting;

  assign in_ready = (state_q == VGC_IDLE);
  assign accept   = in_valid && in_ready;
  assign counting = (state_q == VGC_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VGC_IDLE;
      pos_q   <= '0;
      class_q <= '0;
    end else begin
      case (state_q)
        VGC_IDLE: begin
          if (accept) begin
            state_q <= VGC_COUNT;
            pos_q   <= '0;
          end
        end
        VGC_COUNT: begin
          if (pos_q == LAST_POS) begin
            state_q <= VGC_PICK;
          end
          pos_q <= pos_q + 1'b1;
        end
        VGC_PICK: begin
          class_q <= win_idx;
          state_q <= VGC_HOLD;
        end
        VGC_HOLD: begin
          if (out_ready) begin
            state_q <= VGC_IDLE;
          end
        end
        default: state_q <= VGC_IDLE;
      endcase
    end
  end

  vgc_shift_feed #(
    .NUM_CLASSES(NUM_CLASSES),
    .GROUP_BITS (GROUP_BITS)
  ) u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .shift    (counting),
    .load_bits(in_bits),
    .taps     (taps)
  );

  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_cls
    vgc_bit_counter #(
      .WIDTH(SW)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .step  (counting),
      .bit_in(taps[i]),
      .count (out_scores[i*SW +: SW])
    );
  end

  vgc_max_pick #(
    .NUM_CLASSES(NUM_CLASSES),
    .SW         (SW),
    .IW         (IW)
  ) u_pick (
    .scores (out_scores),
    .win_idx(win_idx)
  );

  assign out_valid = (state_q == VGC_HOLD);
  assign out_class = class_q;

endmodule

// File: rtl/vote_group_classifier_checker.sv
module vote_group_classifier_checker #(
  parameter int NUM_CLASSES = 10,
  parameter int GROUP_BITS  = 100
) (
  input logic                                                   clk,
  input logic                                                   rst_n,
  input logic                                                   in_valid,
  input logic                                                   in_ready,
  input logic                                                   out_valid,
  input logic                                                   out_ready,
  input logic [vgc_pkg::index_width(NUM_CLASSES)-1:0]           out_class,
  input logic [NUM_CLASSES*vgc_pkg::score_width(GROUP_BITS)-1:0] out_scores
);
  localparam int SW = vgc_pkg::score_width(GROUP_BITS);

  int unsigned since_accept;
  logic [SW-1:0] win_score;

  assign win_score = out_scores[out_class*SW +: SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_accept <= 0;
    end else if (in_valid && in_ready) begin
      since_accept <= 0;
    end else if (since_accept < GROUP_BITS + 8) begin
      since_accept <= since_accept + 1;
    end
  end

  // R5: result appears a fixed number of cycles after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> since_accept == GROUP_BITS + 1);

  // R6: nothing is accepted while a result is pending or being formed
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7: stalled result holds
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_scores));

  // R7: consumed result frees the block
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  a_r3_class_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class < NUM_CLASSES);

  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_cls
    // R2: a score never exceeds its slice width
    a_r2_score_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_scores[i*SW +: SW] <= GROUP_BITS);
    // R3: no class beats the winner
    a_r3_winner_max: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_scores[i*SW +: SW] <= win_score);
    // R4: lower indices are strictly below the winner
    a_r4_low_index_tie: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (i < out_class) |-> out_scores[i*SW +: SW] < win_score);
  end

endmodule

bind vote_group_classifier vote_group_classifier_checker #(
  .NUM_CLASSES(NUM_CLASSES),
  .GROUP_BITS (GROUP_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_class (out_class),
  .out_scores(out_scores)
);

// File: tb/vote_group_classifier_bench.sv
module vote_group_classifier_bench;
  localparam int K     = 10;
  localparam int G     = 100;
  localparam int TOTAL = K * G;
  localparam int SW    = $clog2(G + 1);
  localparam int IW    = $clog2(K);

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic out_ready = 0;
  logic [TOTAL-1:0] in_bits = '0;
  logic in_ready, out_valid;
  logic [IW-1:0] out_class;
  logic [K*SW-1:0] out_scores;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  vote_group_classifier #(.NUM_CLASSES(K), .GROUP_BITS(G)) u_vote_group_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_scores(out_scores));

  function automatic int ref_score(input logic [TOTAL-1:0] v, input int c);
    int n = 0;
    for (int b = 0; b < G; b++) n += int'(v[c*G + b]);
    return n;
  endfunction

  function automatic int ref_class(input logic [TOTAL-1:0] v);
    int best = ref_score(v, 0);
    int idx = 0;
    for (int c = 1; c < K; c++) begin
      if (ref_score(v, c) > best) begin
        best = ref_score(v, c);
        idx = c;
      end
    end
    return idx;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // hold: cycles out_ready stays low; noise: offer ~v while busy
  task automatic run_case(input logic [TOTAL-1:0] v, input int hold, input bit noise,
                          input bit check_lat);
    int lat;
    int cls;
    @(negedge clk);
    in_valid = 1;
    in_bits = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    if (noise) in_bits = ~v; else in_valid = 0;
    chk("R6 in_ready low after accept", int'(in_ready), 0);
    lat = 1;
    while (!out_valid) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 0;
    if (check_lat) chk("R5 latency", lat, G + 2);
    cls = int'(out_class);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R7 out_valid held", int'(out_valid), 1);
      chk("R7 class held", int'(out_class), cls);
      chk("R7 in_ready low while held", int'(in_ready), 0);
    end
    for (int c = 0; c < K; c++)
      chk("R1 R2 R9 score", int'(out_scores[c*SW +: SW]), ref_score(v, c));
    chk("R3 R4 class", int'(out_class), ref_class(v));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk("R7 out_valid after take", int'(out_valid), 0);
    chk("R7 in_ready after take", int'(in_ready), 1);
  endtask

  function automatic logic [TOTAL-1:0] fill_groups(input int c0, input int n0,
                                                   input int c1, input int n1);
    logic [TOTAL-1:0] v = '0;
    for (int b = 0; b < n0; b++) v[c0*G + b] = 1'b1;
    for (int b = 0; b < n1; b++) v[c1*G + G - 1 - b] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [TOTAL-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R8 out_valid reset", int'(out_valid), 0);
    chk("R8 in_ready reset", int'(in_ready), 1);
    chk("R8 scores reset", int'(out_scores == '0), 1);
    rst_n = 1;
    @(negedge clk);

    // R4: all ones, every class ties at G
    run_case({TOTAL{1'b1}}, 0, 0, 1);
    // R9: all zeros right after all ones
    run_case('0, 0, 0, 1);
    // R3: only last slice populated
    run_case(fill_groups(K-1, G, 0, 0), 2, 0, 0);
    // R4: tie between classes 3 and 7
    run_case(fill_groups(3, 40, 7, 40), 0, 0, 0);
    // R1: bits straddling the 2/3 slice boundary
    v = '0;
    v[3*G-1] = 1'b1;
    v[3*G] = 1'b1;
    v[3*G+1] = 1'b1;
    run_case(v, 0, 0, 0);
    // R6: noise on the input while counting, plus a stall (R7)
    run_case(fill_groups(5, 60, 2, 59), 4, 1, 1);

    for (int n = 0; n < 40; n++) begin
      v = '0;
      for (int c = 0; c < K; c++) begin
        int dens = $urandom_range(100);
        for (int b = 0; b < G; b++)
          v[c*G + b] = ($urandom_range(99) < dens);
      end
      run_case(v, $urandom_range(3), n[0], n % 5 == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule